// File: doc/BRIEF.md
# Oversampled Serial Receive Recovery

This block recovers bytes from an asynchronous serial line that is sampled sixteen times per bit period. A one-cycle tick input marks each sampling instant; between ticks the block holds its state. The receiver waits for the line to be seen high. It then looks for a low sample and treats that sample as the first sub-slot of a start bit. Each bit's value comes from a two-of-three vote over sub-slots 8, 9 and 10. After eight data bits, least significant first, one stop bit is checked.

A completed byte is written to an output register and raises a full flag. Two error flags are kept beside it. The noise flag marks disagreeing mid-bit samples. The framing flag marks a stop bit that voted low. A read strobe clears all three flags. A mode input selects a stricter, smart-card-style start validation. In that mode, a high vote in the start bit's middle rejects the frame. A standing framing flag also stops any further reception until the byte is read.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, rx_byte is 0 and byte_ready, noise_flag and frame_err are all 0.
- R2: A frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit, each 16 ticks long. Each bit takes the majority of its sub-slot 8, 9 and 10 samples. The byte and byte_ready are updated at the clock edge of the stop bit's sub-slot-10 tick.
- R3: A start is only sought after a high sample has been seen. The first low sample is sub-slot 1. A high sample in sub-slots 2 to 7 of the start bit abandons the frame, and no byte is delivered.
- R4: Disagreeing sub-slot 8–10 samples in any data or stop bit set noise_flag; the majority value is still used.
- R5: With sc_mode = 0, any high sample among the start bit's sub-slots 8–10 sets noise_flag, and the frame is still received.
- R6: With sc_mode = 1, a start bit whose sub-slot 8–10 majority is high is rejected and no byte is delivered. A low majority with one high sample is accepted and sets noise_flag.
- R7: With sc_mode = 0, a stop bit whose majority is low sets frame_err in the same cycle as byte_ready. This includes an all-zero break frame.
- R8: With sc_mode = 1, a low stop bit delivers the byte with frame_err = 0.
- R9: While sc_mode = 1 and frame_err = 1, no new start is accepted and rx_byte is unchanged. Reception resumes once a read has cleared frame_err.
- R10: A rd_strobe clears byte_ready, noise_flag and frame_err on the next edge. A flag being set in that same cycle takes precedence.
- R11: Receive state advances only on clock cycles where os_tick is 1; rx_in is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| sc_mode | input | 1 | Smart-card-style start validation, framing check off |
| rd_strobe | input | 1 | Read of the received byte; clears flags |
| rx_byte | output | 8 | Last received byte |
| byte_ready | output | 1 | A byte has been received and not yet read |
| noise_flag | output | 1 | Mid-bit samples disagreed since last read |
| frame_err | output | 1 | Stop bit found low on last byte |

## Verification
A wrong sub-slot counter or bit index shows up as a shifted or corrupted rx_byte. It can also show as byte_ready rising on the wrong clock. Both are visible at the end of the first frame, roughly 154 ticks after the start edge. A wrong start-validation decision shows within one bit period as a stray noise_flag, or as a byte that should never have arrived. A wrong blocking state shows as a changed rx_byte during a frame sent while frame_err is held in smart-card mode. The bench compares all outputs with a behavioural model on every clock, so any of these appears on the first clock where it differs.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_ARM   = 3'd0,
    RX_HUNT  = 3'd1,
    RX_START = 3'd2,
    RX_DATA  = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int N = 3
) (
  input  logic [N-1:0] samples,
  output logic         maj,
  output logic         split,
  output logic         any_hi
);
  always_comb begin
    maj    = ($countones(samples) > (N / 2));
    any_hi = |samples;
    split  = any_hi && !(&samples);
  end

  always_comb begin
    if (samples == '0) assert_vote_low_R2: assert (!maj);
  end
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic          sc_mode,
  input  logic          fe_flag,
  output logic          done_o,
  output logic          fe_o,
  output logic          noise_o,
  output logic [DW-1:0] byte_o
);
  localparam int RTW = $clog2(OSR + 1);
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [RTW-1:0] MID_A = RTW'(OSR / 2);
  localparam logic [RTW-1:0] MID_B = RTW'(OSR / 2 + 1);
  localparam logic [RTW-1:0] MID_C = RTW'(OSR / 2 + 2);
  localparam logic [RTW-1:0] LAST  = RTW'(OSR);
  localparam logic [BW-1:0]  LASTBIT = BW'(DW - 1);

  rx_state_t      st;
  logic [RTW-1:0] rt, idx;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  shreg;
  logic [1:0]     early;
  logic           vmaj, vsplit, vany, at_vote, blk;

  uart_rx_vote #(.N(3)) u_vote (
    .samples ({rx, early[1], early[0]}),
    .maj     (vmaj),
    .split   (vsplit),
    .any_hi  (vany)
  );

  always_comb begin
    idx     = (rt == LAST) ? RTW'(1) : rt + RTW'(1);
    at_vote = tick && (idx == MID_C);
    blk     = sc_mode && fe_flag;
    done_o  = at_vote && (st == RX_STOP);
    fe_o    = done_o && !vmaj && !sc_mode;
    noise_o = 1'b0;
    if (at_vote) begin
      case (st)
        RX_START:        noise_o = sc_mode ? (vsplit && !vmaj) : vany;
        RX_DATA, RX_STOP: noise_o = vsplit;
        default:         noise_o = 1'b0;
      endcase
    end
  end

  assign byte_o = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_ARM;
      rt    <= '0;
      bitn  <= '0;
      shreg <= '0;
      early <= '0;
    end else if (tick) begin
      if (st == RX_START || st == RX_DATA || st == RX_STOP) begin
        rt <= idx;
        if (idx == MID_A) early[0] <= rx;
        if (idx == MID_B) early[1] <= rx;
      end
      case (st)
        RX_ARM: if (rx) st <= RX_HUNT;
        RX_HUNT: begin
          if (!rx && !blk) begin
            st <= RX_START;
            rt <= RTW'(1);
          end
        end
        RX_START: begin
          if (idx >= RTW'(2) && idx < MID_A && rx) begin
            st <= RX_HUNT;
          end else if (idx == MID_C && sc_mode && vmaj) begin
            st <= RX_ARM;
          end else if (idx == LAST) begin
            st   <= RX_DATA;
            bitn <= '0;
          end
        end
        RX_DATA: begin
          if (idx == MID_C) shreg <= {vmaj, shreg[DW-1:1]};
          if (idx == LAST) begin
            if (bitn == LASTBIT) st <= RX_STOP;
            else bitn <= bitn + BW'(1);
          end
        end
        RX_STOP: if (idx == MID_C) st <= RX_ARM;
        default: st <= RX_ARM;
      endcase
    end
  end

  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(st) && $stable(rt)));
  assert_rt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START || st == RX_DATA || st == RX_STOP) |-> (rt >= RTW'(1) && rt <= LAST));
  assert_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (st == RX_HUNT && blk) |=> (st == RX_HUNT));
  assert_sc_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (at_vote && st == RX_START && sc_mode && vmaj) |=> (st == RX_ARM));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] byte_in,
  input  logic          fe_in,
  input  logic          noise_in,
  input  logic          rd,
  output logic [DW-1:0] data_q,
  output logic          full_q,
  output logic          noise_q,
  output logic          fe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      noise_q <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      if (done) begin
        data_q <= byte_in;
        full_q <= 1'b1;
        fe_q   <= fe_in;
      end else if (rd) begin
        full_q <= 1'b0;
        fe_q   <= 1'b0;
      end
      if (noise_in) noise_q <= 1'b1;
      else if (rd)  noise_q <= 1'b0;
    end
  end

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && !done && !noise_in) |=> (!full_q && !fe_q && !noise_q));
  assert_full_source_R2: assert property (@(posedge clk) disable iff (rst)
    (!full_q && !done) |=> !full_q);
  assert_fe_source_R7: assert property (@(posedge clk) disable iff (rst)
    (!fe_q && !done) |=> !fe_q);
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          rx_in,
  input  logic          sc_mode,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_byte,
  output logic          byte_ready,
  output logic          noise_flag,
  output logic          frame_err
);
  logic          done, fe_now, noise_now;
  logic [DW-1:0] shifted;

  uart_rx_ctrl #(.OSR(OSR), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .rx      (rx_in),
    .sc_mode (sc_mode),
    .fe_flag (frame_err),
    .done_o  (done),
    .fe_o    (fe_now),
    .noise_o (noise_now),
    .byte_o  (shifted)
  );

  uart_rx_flags #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .byte_in  (shifted),
    .fe_in    (fe_now),
    .noise_in (noise_now),
    .rd       (rd_strobe),
    .data_q   (rx_byte),
    .full_q   (byte_ready),
    .noise_q  (noise_flag),
    .fe_q     (frame_err)
  );
endmodule

// File: tb/tb_uart_rx_recover.sv
module tb_uart_rx_recover;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rx = 1'b1, sc = 1'b0, rd = 1'b0;
  logic [7:0] rx_byte;
  logic byte_ready, noise_flag, frame_err;

  always #4 clk = ~clk;

  uart_rx_recover dut (
    .clk(clk), .rst(rst), .os_tick(tick), .rx_in(rx), .sc_mode(sc),
    .rd_strobe(rd), .rx_byte(rx_byte), .byte_ready(byte_ready),
    .noise_flag(noise_flag), .frame_err(frame_err)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // behavioural reference model, advanced on every clock
  bit m_armed, m_in, m_full, m_noise, m_fe, old_fe;
  bit set_full, set_noise, new_fe, s;
  int m_pos, k, w, ones;
  bit [7:0] m_byte, m_data;
  bit mid_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_armed = 0; m_in = 0; m_full = 0; m_noise = 0; m_fe = 0;
      m_pos = 0; m_byte = 0; m_data = 0; mid_q.delete();
    end else begin
      set_full = 0; set_noise = 0; new_fe = 0; old_fe = m_fe;
      if (tick) begin
        s = rx;
        if (!m_in) begin
          if (!m_armed) m_armed = s;
          else if (!s && !(sc && old_fe)) begin m_in = 1; m_pos = 1; mid_q.delete(); end
        end else begin
          m_pos++;
          k = (m_pos - 1) / 16;
          w = (m_pos - 1) % 16 + 1;
          if (k == 0 && w >= 2 && w <= 7 && s) begin
            m_in = 0; m_armed = 1;
          end else if (w >= 8 && w <= 10) begin
            mid_q.push_back(s);
            if (w == 10) begin
              ones = 0;
              foreach (mid_q[i]) ones += mid_q[i];
              mid_q.delete();
              if (k == 0) begin
                if (sc) begin
                  if (ones >= 2) begin m_in = 0; m_armed = 0; end
                  else if (ones == 1) set_noise = 1;
                end else if (ones > 0) set_noise = 1;
              end else if (k <= 8) begin
                m_byte[k-1] = (ones >= 2);
                if (ones == 1 || ones == 2) set_noise = 1;
              end else begin
                set_full = 1;
                new_fe = (ones < 2) && !sc;
                if (ones == 1 || ones == 2) set_noise = 1;
                m_in = 0; m_armed = 0;
              end
            end
          end
        end
      end
      if (set_full) begin m_full = 1; m_fe = new_fe; m_data = m_byte; end
      else if (rd) begin m_full = 0; m_fe = 0; end
      if (set_noise) m_noise = 1;
      else if (rd) m_noise = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (rx_byte !== m_data || byte_ready !== m_full || noise_flag !== m_noise || frame_err !== m_fe) begin
        miscompares++;
        $display("FAIL R2 model: act byte=%0h full=%0b noise=%0b fe=%0b exp byte=%0h full=%0b noise=%0b fe=%0b",
                 rx_byte, byte_ready, noise_flag, frame_err, m_data, m_full, m_noise, m_fe);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic t1(input bit v);
    @(negedge clk); rx = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic send_bit(input bit v, input bit [2:0] m);
    for (int p = 1; p <= 16; p++) t1((p >= 8 && p <= 10) ? m[p-8] : v);
  endtask

  task automatic send_frame(input bit [7:0] d, input bit stopv, input bit [2:0] smid, input int noisy);
    for (int i = 0; i < 4; i++) t1(1'b1);
    send_bit(1'b0, smid);
    for (int i = 0; i < 8; i++)
      send_bit(d[i], (i == noisy) ? {d[i], ~d[i], d[i]} : {3{d[i]}});
    send_bit(stopv, {3{stopv}});
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: act running exp finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 byte", rx_byte, 0); chk("R1 full", byte_ready, 0);
    chk("R1 noise", noise_flag, 0); chk("R1 fe", frame_err, 0);

    send_frame(8'hA5, 1'b1, 3'b000, -1);
    chk("R2 byte", rx_byte, 8'hA5); chk("R2 full", byte_ready, 1);
    chk("R2 noise", noise_flag, 0); chk("R2 fe", frame_err, 0);
    rd_pulse();
    chk("R10 full", byte_ready, 0);

    send_frame(8'h6B, 1'b1, 3'b000, 0);
    chk("R4 byte", rx_byte, 8'h6B); chk("R4 noise", noise_flag, 1);
    rd_pulse();
    chk("R10 noise", noise_flag, 0);

    send_frame(8'h3C, 1'b1, 3'b111, -1);
    chk("R5 byte", rx_byte, 8'h3C); chk("R5 noise", noise_flag, 1);
    rd_pulse();

    for (int i = 0; i < 4; i++) t1(1'b1);
    for (int i = 0; i < 3; i++) t1(1'b0);
    for (int i = 0; i < 170; i++) t1(1'b1);
    chk("R3 false start", byte_ready, 0);
    send_frame(8'hD2, 1'b1, 3'b000, -1);
    chk("R3 byte", rx_byte, 8'hD2);
    rd_pulse();

    @(negedge clk); rx = 1'b0;
    repeat (200) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 no tick", byte_ready, 0);

    send_frame(8'h81, 1'b0, 3'b000, -1);
    chk("R7 full", byte_ready, 1); chk("R7 fe", frame_err, 1);
    rd_pulse();
    chk("R10 fe", frame_err, 0);
    send_frame(8'h00, 1'b0, 3'b000, -1);
    chk("R7 break byte", rx_byte, 0); chk("R7 break fe", frame_err, 1);
    rd_pulse();

    sc = 1'b1;
    send_frame(8'h00, 1'b1, 3'b011, -1);
    chk("R6 rejected", byte_ready, 0); chk("R6 no noise", noise_flag, 0);
    send_frame(8'h4E, 1'b1, 3'b100, -1);
    chk("R6 accepted", rx_byte, 8'h4E); chk("R6 noise", noise_flag, 1);
    rd_pulse();
    send_frame(8'h55, 1'b0, 3'b000, -1);
    chk("R8 full", byte_ready, 1); chk("R8 fe", frame_err, 0);
    rd_pulse();

    sc = 1'b0;
    send_frame(8'h0F, 1'b0, 3'b000, -1);
    chk("R9 setup fe", frame_err, 1);
    sc = 1'b1;
    send_frame(8'h99, 1'b1, 3'b000, -1);
    chk("R9 blocked byte", rx_byte, 8'h0F); chk("R9 fe held", frame_err, 1);
    rd_pulse();
    send_frame(8'h99, 1'b1, 3'b000, -1);
    chk("R9 resumed byte", rx_byte, 8'h99); chk("R9 resumed full", byte_ready, 1);
    for (int i = 0; i < 4; i++) t1(1'b1);
    summary();
  end
endmodule